// File: doc/BRIEF.md
# Bipolar Line-Code Transmit Encoder

This block is the per-channel transmit encoder of a 2.048 Mbit/s E1 line port. Each clock it samples one bit period of NRZ input and turns it into a positive-pulse or negative-pulse command for an analog line driver. The driver itself is not part of the block.

Two input pins carry the data, and their meaning depends on the mode. In single-rail operation, `data_p_i` carries the NRZ bit. That bit is encoded with alternate mark inversion (AMI) or with HDB3 zero substitution, chosen by `hdb3_en_i`. In this mode `data_n_i` serves as a test strobe: with AMI selected, a rising edge on it forces a bipolar violation. In dual-rail operation the two pins are the positive and negative rails and map straight onto the pulse outputs. A dual-rail channel whose negative rail is held high for a long run falls back to single-rail encoding until that rail drops.

Every mode goes through the same four-slot pipeline. HDB3 needs that depth to look ahead over a run of zeros, so a sample always appears on the outputs a fixed number of clocks later, whatever the mode. `clk` is the sampling edge: the integrator feeds it from the inverted transmit clock, so that data is captured on the falling edge of the line clock.

Top module: `tx_bipolar_enc`

## Requirements
- R1: While `rst` is high at a clock edge, both pulse outputs clear, and the first pulse produced for a one after reset is positive.
- R2: A sample taken at clock edge k drives the pulse outputs from edge k+4 onward, in every mode.
- R3: In single-rail AMI mode, a zero gives no pulse and each one gives a pulse opposite in polarity to the previous pulse.
- R4: In single-rail HDB3 mode, four consecutive zeros never leave the block as four spaces. The fourth zero becomes a violation V, a pulse of the same polarity as the previous pulse. If an odd number of ordinary ones has entered since the last V, the substitution is 000V.
- R5: In HDB3 mode, when an even number (including zero) of ones has entered since the last V, the first zero of the run becomes a balancing pulse B, which follows the alternation, so the run is sent as B00V.
- R6: In dual-rail mode (`dual_rail_i`=1), the pair {`data_p_i`,`data_n_i`} = 10 gives a positive pulse, 01 gives a negative pulse, and 00 or 11 gives a space.
- R7: In single-rail AMI mode with `dual_rail_i`=0, a rising edge of `data_n_i` makes the next one, or a one sampled on the same edge, go out with the same polarity as the previous pulse. Later ones alternate from that pulse.
- R8: In HDB3 mode, edges on `data_n_i` have no effect on the pulse outputs.
- R9: In dual-rail mode, once `data_n_i` has been sampled high on 17 consecutive edges, every further sample that has `data_n_i` high is encoded as single-rail AMI/HDB3 data from `data_p_i`, with no violation insertion. The first sample with `data_n_i` low is decoded as dual-rail again. Sixteen high samples followed by a low one do not trigger the fallback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (inverted line clock) |
| rst | input | 1 | Synchronous active-high reset |
| dual_rail_i | input | 1 | 1 selects dual-rail rails, 0 selects single-rail data with violation strobe |
| hdb3_en_i | input | 1 | 1 selects HDB3, 0 selects AMI for single-rail encoding |
| data_p_i | input | 1 | NRZ data (single-rail) or positive rail (dual-rail) |
| data_n_i | input | 1 | Violation strobe (single-rail) or negative rail (dual-rail) |
| pos_pulse_o | output | 1 | Positive pulse command for the current bit period |
| neg_pulse_o | output | 1 | Negative pulse command for the current bit period |

## Verification
The assertions assume that `dual_rail_i` and `hdb3_en_i` stay fixed between resets. The latency and polarity properties are written against a pipeline whose contents were all produced under one configuration. The stimulus therefore changes configuration only while `rst` is high, and it restarts the channel for every pattern. Within a pattern, the data and strobe pins change every bit period in any combination, including strobe edges that coincide with ones, long negative-rail runs of exactly sixteen and more than sixteen samples, and zero runs on both parities of the substitution rule.

// File: rtl/tx_line_pkg.sv
package tx_line_pkg;

    // Lookahead depth required by the four-zero substitution rule.
    localparam int PIPE_DEPTH = 4;

    // Symbol classes carried through the pipeline.
    typedef enum logic [2:0] {
        SYM_IDLE = 3'd0,  // filler after reset, not part of any zero run
        SYM_ZERO = 3'd1,  // space
        SYM_ONE  = 3'd2,  // ordinary mark, alternates
        SYM_BAL  = 3'd3,  // balancing mark, alternates
        SYM_VIOL = 3'd4,  // violation, repeats previous polarity
        SYM_DPOS = 3'd5,  // direct positive pulse from the rails
        SYM_DNEG = 3'd6   // direct negative pulse from the rails
    } sym_t;

    typedef struct packed {
        logic pos;
        logic neg;
    } pulse_t;

    // Pulse for an alternating mark given the polarity of the previous pulse.
    function automatic pulse_t alt_pulse(logic last_pos);
        pulse_t p;
        p.pos = ~last_pos;
        p.neg = last_pos;
        return p;
    endfunction

endpackage

// File: rtl/tx_rail_front.sv
module tx_rail_front
    import tx_line_pkg::*;
#(
    parameter int RUN_LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic dual_rail_i,
    input  logic hdb3_en_i,
    input  logic data_p_i,
    input  logic data_n_i,
    output sym_t sym_o,
    output logic sub_en_o,
    output logic fallback_o
);

    localparam int CW = $clog2(RUN_LIMIT + 1);
    localparam logic [CW-1:0] RUN_MAX = CW'(RUN_LIMIT);

    logic [CW-1:0] run_q;
    logic          fb_q;
    logic          n_prev_q;
    logic          pend_q;

    logic single_rail;
    logic viol_mode;
    logic viol_now;

    always_comb begin
        single_rail = !dual_rail_i || (fb_q && data_n_i);
        viol_mode   = !dual_rail_i && !hdb3_en_i;
        viol_now    = viol_mode && (pend_q || (data_n_i && !n_prev_q));
        sub_en_o    = single_rail && hdb3_en_i;
        if (single_rail) begin
            if (data_p_i) sym_o = viol_now ? SYM_VIOL : SYM_ONE;
            else          sym_o = SYM_ZERO;
        end else begin
            unique case ({data_p_i, data_n_i})
                2'b10:   sym_o = SYM_DPOS;
                2'b01:   sym_o = SYM_DNEG;
                default: sym_o = SYM_ZERO;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= '0;
            fb_q     <= 1'b0;
            n_prev_q <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            if (!data_n_i)            run_q <= '0;
            else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
            fb_q     <= data_n_i && (run_q == RUN_MAX);
            n_prev_q <= data_n_i;
            pend_q   <= viol_now && !data_p_i;
        end
    end

    assign fallback_o = fb_q;

endmodule

// File: rtl/tx_hdb3_pipe.sv
module tx_hdb3_pipe
    import tx_line_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  sym_t                   sym_i,
    input  logic                   sub_en_i,
    output sym_t [PIPE_DEPTH-1:0]  sr_o
);

    sym_t [PIPE_DEPTH-1:0] sr_q;
    logic                  par_odd_q;
    logic                  run_full;

    always_comb begin
        run_full = sub_en_i && (sym_i == SYM_ZERO);
        for (int i = 0; i < PIPE_DEPTH - 1; i++) begin
            if (sr_q[i] != SYM_ZERO) run_full = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q      <= {PIPE_DEPTH{SYM_IDLE}};
            par_odd_q <= 1'b0;
        end else begin
            for (int i = 1; i < PIPE_DEPTH; i++) sr_q[i] <= sr_q[i-1];
            if (run_full) begin
                sr_q[0]            <= SYM_VIOL;
                sr_q[PIPE_DEPTH-1] <= par_odd_q ? SYM_ZERO : SYM_BAL;
                par_odd_q          <= 1'b0;
            end else begin
                sr_q[0] <= sym_i;
                if (sym_i == SYM_ONE)       par_odd_q <= ~par_odd_q;
                else if (sym_i == SYM_VIOL) par_odd_q <= 1'b0;
            end
        end
    end

    assign sr_o = sr_q;

endmodule

// File: rtl/tx_pulse_out.sv
module tx_pulse_out
    import tx_line_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  sym_t   sym_i,
    output pulse_t pulse_o,
    output logic   last_pos_o
);

    pulse_t pulse_q;
    logic   last_pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q    <= '0;
            last_pos_q <= 1'b0;
        end else begin
            unique case (sym_i)
                SYM_ONE, SYM_BAL: begin
                    pulse_q    <= alt_pulse(last_pos_q);
                    last_pos_q <= ~last_pos_q;
                end
                SYM_VIOL: pulse_q <= '{pos: last_pos_q, neg: ~last_pos_q};
                SYM_DPOS: begin
                    pulse_q    <= '{pos: 1'b1, neg: 1'b0};
                    last_pos_q <= 1'b1;
                end
                SYM_DNEG: begin
                    pulse_q    <= '{pos: 1'b0, neg: 1'b1};
                    last_pos_q <= 1'b0;
                end
                default: pulse_q <= '0;
            endcase
        end
    end

    assign pulse_o    = pulse_q;
    assign last_pos_o = last_pos_q;

endmodule

// File: rtl/tx_bipolar_enc.sv
module tx_bipolar_enc
    import tx_line_pkg::*;
#(
    parameter int FALLBACK_RUN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic dual_rail_i,
    input  logic hdb3_en_i,
    input  logic data_p_i,
    input  logic data_n_i,
    output logic pos_pulse_o,
    output logic neg_pulse_o
);

    sym_t                  sym_in;
    logic                  sub_en;
    logic                  fb_q;
    sym_t [PIPE_DEPTH-1:0] pipe_sr;
    pulse_t                pulse;
    logic                  last_pos;

    tx_rail_front #(.RUN_LIMIT(FALLBACK_RUN)) front_i (
        .clk        (clk),
        .rst        (rst),
        .dual_rail_i(dual_rail_i),
        .hdb3_en_i  (hdb3_en_i),
        .data_p_i   (data_p_i),
        .data_n_i   (data_n_i),
        .sym_o      (sym_in),
        .sub_en_o   (sub_en),
        .fallback_o (fb_q)
    );

    tx_hdb3_pipe pipe_i (
        .clk     (clk),
        .rst     (rst),
        .sym_i   (sym_in),
        .sub_en_i(sub_en),
        .sr_o    (pipe_sr)
    );

    tx_pulse_out out_i (
        .clk       (clk),
        .rst       (rst),
        .sym_i     (pipe_sr[PIPE_DEPTH-1]),
        .pulse_o   (pulse),
        .last_pos_o(last_pos)
    );

    assign pos_pulse_o = pulse.pos;
    assign neg_pulse_o = pulse.neg;

endmodule

// File: rtl/tx_bipolar_enc_chk.sv
module tx_bipolar_enc_chk
    import tx_line_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  dual_rail_i,
    input logic                  hdb3_en_i,
    input logic                  data_p_i,
    input logic                  data_n_i,
    input logic                  pos_pulse_o,
    input logic                  neg_pulse_o,
    input sym_t                  sym_in,
    input logic                  sub_en,
    input logic                  fb_q,
    input sym_t [PIPE_DEPTH-1:0] pipe_sr,
    input logic                  last_pos
);

    logic [2:0] warm_q;
    always_ff @(posedge clk) begin
        if (rst)               warm_q <= '0;
        else if (warm_q != 3'd5) warm_q <= warm_q + 3'd1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!pos_pulse_o && !neg_pulse_o));

    // R2
    dual_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 3'd5) && $past(dual_rail_i, 5) && $past(data_p_i, 5) && !$past(data_n_i, 5)
        |-> (pos_pulse_o && !neg_pulse_o));

    // R3
    mark_alternates_chk: assert property (@(posedge clk) disable iff (rst)
        (pipe_sr[PIPE_DEPTH-1] == SYM_ONE)
        |=> (pos_pulse_o == !$past(last_pos)) && (neg_pulse_o == $past(last_pos)));

    // R4
    hdb3_no_four_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (sub_en && sym_in == SYM_ZERO)
        |=> !(pipe_sr[0] == SYM_ZERO && pipe_sr[1] == SYM_ZERO &&
              pipe_sr[2] == SYM_ZERO && pipe_sr[3] == SYM_ZERO));

    // R7
    viol_same_pol_chk: assert property (@(posedge clk) disable iff (rst)
        (pipe_sr[PIPE_DEPTH-1] == SYM_VIOL)
        |=> (pos_pulse_o == $past(last_pos)) && (neg_pulse_o == !$past(last_pos)));

    // R8
    hdb3_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        hdb3_en_i |-> (sym_in != SYM_VIOL));

    // R9
    fallback_single_chk: assert property (@(posedge clk) disable iff (rst)
        (dual_rail_i && fb_q && data_n_i)
        |-> (sym_in == SYM_ZERO || sym_in == SYM_ONE));

endmodule

bind tx_bipolar_enc tx_bipolar_enc_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .dual_rail_i(dual_rail_i),
    .hdb3_en_i  (hdb3_en_i),
    .data_p_i   (data_p_i),
    .data_n_i   (data_n_i),
    .pos_pulse_o(pos_pulse_o),
    .neg_pulse_o(neg_pulse_o),
    .sym_in     (sym_in),
    .sub_en     (sub_en),
    .fb_q       (fb_q),
    .pipe_sr    (pipe_sr),
    .last_pos   (last_pos)
);

// File: tb/tx_bipolar_enc_tb_top.sv
module tx_bipolar_enc_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MAXLEN     = 72;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dual_rail = 1'b0;
    logic hdb3_en = 1'b0;
    logic dp = 1'b0;
    logic dn = 1'b0;
    logic pos, neg;

    tx_bipolar_enc dut_i (
        .clk        (clk),
        .rst        (rst),
        .dual_rail_i(dual_rail),
        .hdb3_en_i  (hdb3_en),
        .data_p_i   (dp),
        .data_n_i   (dn),
        .pos_pulse_o(pos),
        .neg_pulse_o(neg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    tgt;
        logic  pos;
        logic  neg;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int n_checks = 0;
    int n_fail   = 0;

    logic p_arr [MAXLEN];
    logic n_arr [MAXLEN];
    logic ep    [MAXLEN];
    logic en    [MAXLEN];
    int   plen;

    task automatic check(string req, logic ap, logic an, logic xp, logic xn);
        n_checks++;
        if (ap !== xp || an !== xn) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: pos/neg got %b%b expected %b%b",
                     req, cyc, ap, an, xp, xn);
        end
    endtask

    // Scoreboard monitor: compare outputs against queued expectations.
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].tgt <= cyc) begin
            exp_t e;
            e = exp_q.pop_front();
            if (e.tgt < cyc) begin
                n_checks++;
                n_fail++;
                $display("FAIL %s: expectation for cycle %0d missed, got %b%b expected %b%b",
                         e.req, e.tgt, pos, neg, e.pos, e.neg);
            end else begin
                check(e.req, pos, neg, e.pos, e.neg);
            end
        end
    end

    task automatic set_pat(string ps, string ns);
        plen = ps.len();
        for (int i = 0; i < MAXLEN; i++) begin
            p_arr[i] = (i < plen) && (ps[i] == "1");
            n_arr[i] = (i < ns.len()) && (ns[i] == "1");
        end
    endtask

    // Independent encoder model built from the requirements.
    task automatic model(bit dual, bit hdb3, int total);
        int   sym [MAXLEN];
        logic last, pend, nprev, par, single, violm;
        int   cnt, zeros;
        last = 1'b0; pend = 1'b0; nprev = 1'b0; par = 1'b0;
        cnt = 0; zeros = 0;
        violm = !dual && !hdb3;
        for (int i = 0; i < total; i++) begin
            single = !dual || (cnt >= 17 && n_arr[i]);
            if (violm && n_arr[i] && !nprev) pend = 1'b1;
            if (single) begin
                if (p_arr[i]) begin
                    sym[i] = (violm && pend) ? 3 : 1;
                    if (sym[i] == 3) pend = 1'b0;
                end else begin
                    sym[i] = 0;
                end
            end else begin
                if (p_arr[i] && !n_arr[i])      sym[i] = 4;
                else if (!p_arr[i] && n_arr[i]) sym[i] = 5;
                else                            sym[i] = 0;
            end
            if (!violm) pend = 1'b0;
            cnt   = n_arr[i] ? cnt + 1 : 0;
            nprev = n_arr[i];
            if (sym[i] == 0) begin
                zeros++;
                if (single && hdb3 && zeros >= 4) begin
                    sym[i] = 3;
                    if (!par) sym[i-3] = 2;
                    par = 1'b0;
                    zeros = 0;
                end
            end else begin
                zeros = 0;
                if (sym[i] == 1) par = ~par;
                if (sym[i] == 3) par = 1'b0;
            end
        end
        for (int i = 0; i < total; i++) begin
            ep[i] = 1'b0; en[i] = 1'b0;
            case (sym[i])
                1, 2: begin ep[i] = ~last; en[i] = last; last = ~last; end
                3:    begin ep[i] = last;  en[i] = ~last; end
                4:    begin ep[i] = 1'b1;  last = 1'b1; end
                5:    begin en[i] = 1'b1;  last = 1'b0; end
                default: ;
            endcase
        end
    endtask

    task automatic do_reset(bit dual, bit hdb3);
        @(negedge clk);
        rst = 1'b1; dp = 1'b0; dn = 1'b0;
        dual_rail = dual; hdb3_en = hdb3;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Driver: drive samples and push the expected pulse 5 negedges later.
    task automatic run_case(string req, bit dual, bit hdb3);
        model(dual, hdb3, plen + 4);
        do_reset(dual, hdb3);
        for (int i = 0; i < plen + 4; i++) begin
            dp = p_arr[i];
            dn = n_arr[i];
            if (i < plen) begin
                exp_t e;
                e.tgt = cyc + 5; e.pos = ep[i]; e.neg = en[i]; e.req = req;
                exp_q.push_back(e);
            end
            @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: outputs clear under reset
        do_reset(1'b0, 1'b0);
        check("R1 reset state", pos, neg, 1'b0, 1'b0);

        // R1 first mark positive, R2 latency, R3 AMI alternation
        set_pat("1101000011", "");
        run_case("R1 R2 R3 ami", 1'b0, 1'b0);

        // R4 000V and R5 B00V substitutions
        set_pat("00001000011000000001", "");
        run_case("R4 R5 hdb3", 1'b0, 1'b1);

        // R8 strobe edges ignored in HDB3
        set_pat("1011000010", "0101010101");
        run_case("R8 hdb3 strobe ignored", 1'b0, 1'b1);

        // R7 violation: pending across zeros, and coincident with a one
        set_pat("1010011101", "0100001000");
        run_case("R7 violation", 1'b0, 1'b0);

        // R6 dual-rail mapping, R2 latency
        set_pat("10011001", "01010110");
        run_case("R6 R2 dual rail", 1'b1, 1'b0);

        // R9 fallback after 17 high samples, back to dual on low
        set_pat("01010101010101010111011010", "11111111111111111111000000");
        run_case("R9 fallback", 1'b1, 1'b0);

        // R9 boundary: 16 highs then low, no fallback
        set_pat("000000000000000001111", "111111111111111101111");
        run_case("R9 no fallback at 16", 1'b1, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule